// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the target side of a two-wire serial memory. It holds a byte-wide array of `2**MEM_AW` bytes (8192 bytes when `MEM_AW` is 13). The serial clock and data lines are oversampled on the system clock. Each line goes through a synchronizer and a three-sample majority filter, and edge logic then finds clock edges and start and stop conditions. The block pulls the data line low through an open-drain enable and never drives it high.

A protocol engine compares the device-address byte with three strap inputs. It collects two word-address bytes and keeps one word-address counter that persists between transactions. It serves current-address, random and sequential reads. Write data go to a page staging and commit unit. On a stop, that unit copies the staged bytes into the array and then runs a timed write cycle. While the cycle runs, every device-address byte is left unacknowledged, so a master can poll until the write has finished.

Top module: `eep_slave`

## Requirements
- R1: After reset the data line is released, and clocking a byte without a preceding start gets no acknowledge.
- R2: The device-address byte is bits 7..4 = 1010, bits 3..1 = strap value, bit 0 = direction (1 read, 0 write), sent most significant bit first. A matching byte is acknowledged by pulling the line low on the ninth clock. A byte with the wrong prefix or strap value gets no acknowledge, and the block returns to idle.
- R3: A write carries a high and a low word-address byte. The address is the low `MEM_AW` bits of {high, low}, so high-byte bits above that are ignored. A byte written this way reads back through a random read (dummy write, repeated start, read).
- R4: The word-address counter holds the last accessed address plus one. A current-address read returns the byte at that location.
- R5: In a sequential read each master acknowledge advances the address and sends the next byte. From the last byte of the array the address wraps to 0. A master no-acknowledge ends the read.
- R6: During a write the low five address bits (the 32-byte page offset) advance after each data byte and wrap inside the page. The upper bits are never changed, so neighbouring pages are untouched.
- R7: From the stop of a write until the internal write cycle ends, device-address bytes are not acknowledged. After the cycle ends they are acknowledged again.
- R8: A start in the middle of a byte aborts the transfer and restarts device-address decoding.
- R9: A stop in the middle of a transfer returns the block to idle with the line released. Bytes clocked afterwards without a start get no acknowledge.
- R10: The block changes its data-line enable only while the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired value) |
| strap_i | input | 3 | Board strap value compared with device-address bits 3..1 |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls the data line low |

## Verification
The hardest state to reach from the ports is the busy window that follows a write. A device-address byte must land while the copy and timer are still running, and only a master that issues a new start right after a write stop can get there. The bench keeps the write cycle short: it sends a fresh start and write address straight after the stop of a page write and expects no acknowledge. It then polls until the address is acknowledged again. The array wrap and the page wrap are reached by writing the last array byte and bytes near a page end, then reading across each boundary.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [1:0] {PH_IDLE, PH_RX, PH_TX} phase_e;
    typedef enum logic [1:0] {BY_DEV, BY_AHI, BY_ALO, BY_DATA} byte_e;
    typedef enum logic [1:0] {CM_STAGE, CM_COPY, CM_WAIT} cmode_e;
    localparam logic [3:0] DEV_PREFIX = 4'b1010;
endpackage

// File: rtl/eep_line_filter.sv
module eep_line_filter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o
);
    logic [SYNC_STAGES-1:0] sync_q, sync_d;
    logic [2:0] win_q, win_d;
    logic lvl_q, lvl_d;

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], line_i};
        win_d  = {win_q[1:0], sync_q[SYNC_STAGES-1]};
        // majority of three samples rejects single-cycle glitches
        lvl_d  = (win_q[0] & win_q[1]) | (win_q[0] & win_q[2]) | (win_q[1] & win_q[2]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            win_q  <= '1;
            lvl_q  <= 1'b1;
        end else begin
            sync_q <= sync_d;
            win_q  <= win_d;
            lvl_q  <= lvl_d;
        end
    end

    assign lvl_o = lvl_q;
endmodule

// File: rtl/eep_bus_cond.sv
module eep_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_lvl,
    input  logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic scl_prev_q, sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_lvl;
            sda_prev_q <= sda_lvl;
        end
    end

    always_comb begin
        scl_rise = scl_lvl & ~scl_prev_q;
        scl_fall = ~scl_lvl & scl_prev_q;
        start_p  = scl_lvl & scl_prev_q & sda_prev_q & ~sda_lvl;
        stop_p   = scl_lvl & scl_prev_q & ~sda_prev_q & sda_lvl;
    end
endmodule

// File: rtl/eep_page_commit.sv
module eep_page_commit
    import eep_pkg::*;
#(
    parameter int MEM_AW    = 10,
    parameter int PAGE_AW   = 5,
    parameter int WR_CYCLES = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [MEM_AW-1:0] push_addr_i,
    input  logic [7:0]        push_data_i,
    input  logic              drop_i,
    input  logic              commit_i,
    input  logic [MEM_AW-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic              busy_o
);
    localparam int PAGE_BYTES = 1 << PAGE_AW;
    localparam int ROW_W      = MEM_AW - PAGE_AW;
    localparam int DEPTH      = 1 << MEM_AW;
    localparam int TMR_W      = $clog2(WR_CYCLES + 1);

    typedef struct packed {
        cmode_e                  mode;
        logic [ROW_W-1:0]        row;
        logic [PAGE_AW-1:0]      idx;
        logic [TMR_W-1:0]        tmr;
        logic [PAGE_BYTES-1:0]   vld;
        logic [PAGE_BYTES*8-1:0] pbuf;
    } cstate_t;

    cstate_t s_q, s_d;
    logic [7:0] mem_q [DEPTH];
    logic              mem_we;
    logic [MEM_AW-1:0] mem_wa;
    logic [7:0]        mem_wd;
    logic [PAGE_AW-1:0] off;

    always_comb begin
        s_d    = s_q;
        mem_we = 1'b0;
        mem_wa = {s_q.row, s_q.idx};
        mem_wd = s_q.pbuf[{s_q.idx, 3'b000} +: 8];
        off    = push_addr_i[PAGE_AW-1:0];
        case (s_q.mode)
            CM_STAGE: begin
                if (drop_i) s_d.vld = '0;
                if (push_i) begin
                    s_d.row                     = push_addr_i[MEM_AW-1:PAGE_AW];
                    s_d.pbuf[{off, 3'b000} +: 8] = push_data_i;
                    s_d.vld[off]                = 1'b1;
                end
                if (commit_i && |s_q.vld) begin
                    s_d.mode = CM_COPY;
                    s_d.idx  = '0;
                end
            end
            CM_COPY: begin
                mem_we = s_q.vld[s_q.idx];
                if (s_q.idx == PAGE_AW'(PAGE_BYTES - 1)) begin
                    s_d.mode = CM_WAIT;
                    s_d.tmr  = TMR_W'(WR_CYCLES - 1);
                    s_d.vld  = '0;
                end else begin
                    s_d.idx = s_q.idx + PAGE_AW'(1);
                end
            end
            default: begin
                if (s_q.tmr == '0) s_d.mode = CM_STAGE;
                else               s_d.tmr  = s_q.tmr - TMR_W'(1);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: CM_STAGE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem_q[mem_wa] <= mem_wd;
    end

    assign rd_data_o = mem_q[rd_addr_i];
    assign busy_o    = (s_q.mode != CM_STAGE);
endmodule

// File: rtl/eep_slave.sv
module eep_slave
    import eep_pkg::*;
#(
    parameter int MEM_AW      = 10,
    parameter int PAGE_AW     = 5,
    parameter int WR_CYCLES   = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_pull_o
);
    localparam int HI_W = MEM_AW - 8;

    typedef struct packed {
        phase_e            ph;
        byte_e             kind;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic              rw;
        logic              pull;
        logic [HI_W-1:0]   ahi;
        logic [MEM_AW-1:0] addr;
    } pstate_t;

    logic [1:0] raw_lines, lvl;
    logic scl_lvl, sda_lvl;
    logic scl_rise, scl_fall, start_p, stop_p;
    logic push, drop, commit, busy, dev_hit;
    logic [7:0] rd_data;
    pstate_t st_q, st_d;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        eep_line_filter #(.SYNC_STAGES(SYNC_STAGES)) filt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .lvl_o  (lvl[g])
        );
    end

    assign scl_lvl = lvl[0];
    assign sda_lvl = lvl[1];

    eep_bus_cond cond_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    eep_page_commit #(
        .MEM_AW    (MEM_AW),
        .PAGE_AW   (PAGE_AW),
        .WR_CYCLES (WR_CYCLES)
    ) commit_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_addr_i (st_q.addr),
        .push_data_i (st_q.sh),
        .drop_i      (drop),
        .commit_i    (commit),
        .rd_addr_i   (st_q.addr),
        .rd_data_o   (rd_data),
        .busy_o      (busy)
    );

    assign dev_hit = (st_q.sh[7:4] == DEV_PREFIX) && (st_q.sh[3:1] == strap_i);

    always_comb begin
        st_d   = st_q;
        push   = 1'b0;
        drop   = 1'b0;
        commit = 1'b0;
        if (start_p) begin
            st_d.ph   = PH_RX;
            st_d.kind = BY_DEV;
            st_d.cnt  = '0;
            st_d.pull = 1'b0;
            drop      = 1'b1;
        end else if (stop_p) begin
            st_d.ph   = PH_IDLE;
            st_d.cnt  = '0;
            st_d.pull = 1'b0;
            commit    = 1'b1;
        end else begin
            case (st_q.ph)
                PH_RX: begin
                    if (scl_rise && st_q.cnt != 4'd8) begin
                        st_d.sh  = {st_q.sh[6:0], sda_lvl};
                        st_d.cnt = st_q.cnt + 4'd1;
                    end else if (scl_fall && st_q.cnt == 4'd8 && !st_q.pull) begin
                        // eight bits in: decide acknowledge for this byte
                        case (st_q.kind)
                            BY_DEV: begin
                                if (dev_hit && !busy) begin
                                    st_d.pull = 1'b1;
                                    st_d.rw   = st_q.sh[0];
                                end else begin
                                    st_d.ph = PH_IDLE;
                                end
                            end
                            BY_AHI: begin
                                st_d.ahi  = st_q.sh[HI_W-1:0];
                                st_d.pull = 1'b1;
                            end
                            BY_ALO: begin
                                st_d.addr = {st_q.ahi, st_q.sh};
                                st_d.pull = 1'b1;
                            end
                            default: begin
                                push      = 1'b1;
                                st_d.addr = {st_q.addr[MEM_AW-1:PAGE_AW],
                                             st_q.addr[PAGE_AW-1:0] + PAGE_AW'(1)};
                                st_d.pull = 1'b1;
                            end
                        endcase
                    end else if (scl_fall && st_q.cnt == 4'd8) begin
                        // end of acknowledge clock
                        st_d.pull = 1'b0;
                        st_d.cnt  = '0;
                        case (st_q.kind)
                            BY_DEV: begin
                                if (st_q.rw) begin
                                    st_d.ph   = PH_TX;
                                    st_d.sh   = rd_data;
                                    st_d.pull = ~rd_data[7];
                                end else begin
                                    st_d.kind = BY_AHI;
                                end
                            end
                            BY_AHI:  st_d.kind = BY_ALO;
                            default: st_d.kind = BY_DATA;
                        endcase
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (st_q.cnt < 4'd7) begin
                            st_d.sh   = {st_q.sh[6:0], 1'b0};
                            st_d.pull = ~st_q.sh[6];
                            st_d.cnt  = st_q.cnt + 4'd1;
                        end else if (st_q.cnt == 4'd7) begin
                            st_d.pull = 1'b0;
                            st_d.cnt  = 4'd8;
                            st_d.addr = st_q.addr + MEM_AW'(1);
                        end else if (st_q.cnt == 4'd9) begin
                            st_d.sh   = rd_data;
                            st_d.pull = ~rd_data[7];
                            st_d.cnt  = '0;
                        end
                    end else if (scl_rise && st_q.cnt == 4'd8) begin
                        if (!sda_lvl) st_d.cnt = 4'd9;
                        else          st_d.ph  = PH_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, kind: BY_DEV, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_pull_o = st_q.pull;
endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk
    import eep_pkg::*;
#(
    parameter int MEM_AW  = 10,
    parameter int PAGE_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_pull,
    input logic              scl_lvl,
    input logic              start_p,
    input logic              stop_p,
    input logic              busy,
    input phase_e            ph,
    input byte_e             kind,
    input logic [3:0]        cnt,
    input logic              push,
    input logic [MEM_AW-1:0] addr
);
    assert_start_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> (ph == PH_RX && kind == BY_DEV && cnt == 4'd0));

    assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> (ph == PH_IDLE && !sda_pull));

    assert_busy_no_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ph == PH_RX && kind == BY_DEV) |-> !sda_pull);

    assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_lvl);

    assert_page_row_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (addr[MEM_AW-1:PAGE_AW] == $past(addr[MEM_AW-1:PAGE_AW])));
endmodule

bind eep_slave eep_slave_chk #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_pull (sda_pull_o),
    .scl_lvl  (scl_lvl),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .busy     (busy),
    .ph       (st_q.ph),
    .kind     (st_q.kind),
    .cnt      (st_q.cnt),
    .push     (push),
    .addr     (st_q.addr)
);

// File: tb/eep_slave_tb_top.sv
module eep_slave_tb_top;
    localparam int CLK_P = 10;
    localparam int Q     = 8;       // quarter of a serial bit, in system clocks
    localparam int WR_CYC = 600;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W = 8'hAA;   // 1010_101_0
    localparam logic [7:0] DEV_R = 8'hAB;   // 1010_101_1

    // write address, read address, data
    localparam logic [39:0] VEC [6] = '{
        40'h0010_0010_5A,
        40'hF821_0021_C3,
        40'h0133_0133_01,
        40'hA2FE_02FE_FF,
        40'h0377_0377_00,
        40'h7C40_0040_96
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_pull;
    logic sda_line;
    int n_chk = 0;
    int n_fail = 0;
    int viol = 0;
    logic prev_pull = 1'b0;
    logic done = 1'b0;

    assign sda_line = m_sda & ~sda_pull;

    always #(CLK_P/2) clk = ~clk;

    eep_slave #(.MEM_AW(10), .PAGE_AW(5), .WR_CYCLES(WR_CYC), .SYNC_STAGES(2)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .strap_i    (STRAP),
        .sda_pull_o (sda_pull)
    );

    // R10 monitor: enable must not move while the raw clock is high
    always @(negedge clk) begin
        if (rst_n && scl && (sda_pull !== prev_pull)) viol = viol + 1;
        prev_pull = sda_pull;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_clk(input logic b, output logic s);
        scl = 1'b0; tick(Q);
        m_sda = b;  tick(Q);
        scl = 1'b1; tick(Q);
        s = sda_line; tick(Q);
        scl = 1'b0;
    endtask

    task automatic start_c();
        scl = 1'b0;   tick(Q);
        m_sda = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        m_sda = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic stop_c();
        scl = 1'b0;   tick(Q);
        m_sda = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_clk(b[i], s);
        bit_clk(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_clk(1'b1, s);
            d[i] = s;
        end
        bit_clk(~mack, s);
    endtask

    task automatic wait_ready(output int polls);
        logic a;
        polls = 0;
        a = 1'b0;
        while (!a && polls < 40) begin
            start_c();
            send_byte(DEV_W, a);
            stop_c();
            polls++;
        end
    endtask

    task automatic write1(input logic [15:0] a, input logic [7:0] d, output logic ok);
        logic k0, k1, k2, k3;
        int p;
        start_c();
        send_byte(DEV_W, k0);
        send_byte(a[15:8], k1);
        send_byte(a[7:0], k2);
        send_byte(d, k3);
        stop_c();
        ok = k0 & k1 & k2 & k3;
        wait_ready(p);
    endtask

    task automatic set_addr(input logic [15:0] a, output logic ok);
        logic k0, k1, k2;
        start_c();
        send_byte(DEV_W, k0);
        send_byte(a[15:8], k1);
        send_byte(a[7:0], k2);
        ok = k0 & k1 & k2;
    endtask

    task automatic rand_read(input logic [15:0] a, output logic [7:0] d, output logic ok);
        logic k0, k1;
        set_addr(a, k0);
        start_c();
        send_byte(DEV_R, k1);
        recv_byte(1'b0, d);
        stop_c();
        ok = k0 & k1;
    endtask

    initial begin
        logic ok, ack, s;
        logic [7:0] d0, d1;
        int polls;

        tick(5);
        chk("R1 pull during reset", {31'd0, sda_pull}, 32'd0);
        rst_n = 1'b1;
        tick(5);
        chk("R1 pull after reset", {31'd0, sda_pull}, 32'd0);
        send_byte(DEV_W, ack);
        chk("R1 no ack without start", {31'd0, ack}, 32'd0);
        stop_c();

        // R2: address matching
        start_c(); send_byte(8'hA0, ack); stop_c();
        chk("R2 strap mismatch nack", {31'd0, ack}, 32'd0);
        start_c(); send_byte(8'hBA, ack); stop_c();
        chk("R2 prefix mismatch nack", {31'd0, ack}, 32'd0);
        start_c(); send_byte(DEV_W, ack); stop_c();
        chk("R2 match ack", {31'd0, ack}, 32'd1);

        // R3: table of byte writes and random reads
        for (int i = 0; i < 6; i++) begin
            write1(VEC[i][39:24], VEC[i][7:0], ok);
            chk("R3 write acks", {31'd0, ok}, 32'd1);
            rand_read(VEC[i][23:8], d0, ok);
            chk("R3 random read data", {24'd0, d0}, {24'd0, VEC[i][7:0]});
        end

        // R5 / R4: array wrap and current address read
        write1(16'h03FF, 8'h11, ok);
        write1(16'h0000, 8'h22, ok);
        write1(16'h0001, 8'h33, ok);
        set_addr(16'h03FF, ok);
        start_c();
        send_byte(DEV_R, ack);
        recv_byte(1'b1, d0);
        recv_byte(1'b0, d1);
        stop_c();
        chk("R5 last array byte", {24'd0, d0}, 32'h11);
        chk("R5 wrap to byte 0", {24'd0, d1}, 32'h22);
        start_c();
        send_byte(DEV_R, ack);
        recv_byte(1'b0, d0);
        stop_c();
        chk("R4 current read ack", {31'd0, ack}, 32'd1);
        chk("R4 current read data", {24'd0, d0}, 32'h33);

        // R6: page write wraps inside the page; R7: busy polling
        write1(16'h00C0, 8'h77, ok);
        start_c();
        send_byte(DEV_W, ack);
        send_byte(8'h00, ack);
        send_byte(8'hBE, ack);
        send_byte(8'hD0, ack);
        send_byte(8'hD1, ack);
        send_byte(8'hD2, ack);
        send_byte(8'hD3, ack);
        stop_c();
        start_c();
        send_byte(DEV_W, ack);
        stop_c();
        chk("R7 nack while busy", {31'd0, ack}, 32'd0);
        wait_ready(polls);
        chk("R7 ack after cycle", {31'd0, (polls < 40)}, 32'd1);
        rand_read(16'h00BE, d0, ok); chk("R6 offset 30", {24'd0, d0}, 32'hD0);
        rand_read(16'h00BF, d0, ok); chk("R6 offset 31", {24'd0, d0}, 32'hD1);
        rand_read(16'h00A0, d0, ok); chk("R6 wrapped offset 0", {24'd0, d0}, 32'hD2);
        rand_read(16'h00A1, d0, ok); chk("R6 wrapped offset 1", {24'd0, d0}, 32'hD3);
        rand_read(16'h00C0, d0, ok); chk("R6 next page untouched", {24'd0, d0}, 32'h77);

        // R8: start in mid-byte restarts decoding
        start_c();
        bit_clk(1'b0, s);
        bit_clk(1'b1, s);
        bit_clk(1'b1, s);
        bit_clk(1'b0, s);
        bit_clk(1'b1, s);
        rand_read(16'h0010, d0, ok);
        chk("R8 acks after abort", {31'd0, ok}, 32'd1);
        chk("R8 data after abort", {24'd0, d0}, 32'h5A);

        // R9: stop in mid-byte returns to idle
        start_c();
        send_byte(DEV_W, ack);
        send_byte(8'h00, ack);
        bit_clk(1'b1, s);
        bit_clk(1'b0, s);
        bit_clk(1'b1, s);
        stop_c();
        tick(2);
        chk("R9 released after stop", {31'd0, sda_pull}, 32'd0);
        send_byte(8'h55, ack);
        chk("R9 no ack after stop", {31'd0, ack}, 32'd0);
        stop_c();

        chk("R10 enable moved with clock high", viol, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule